// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides when a CAN protocol engine may join bus traffic. After a hardware reset it parks the controller in a configuration state. In that state, software sets up bit timing and the message buffers. A software-owned reset-request bit and a hardware-owned reset-status bit form a handshake. Software clears the request, and the block clears the status bit by itself. The block then enters a bus-integration phase, in which it watches the sampled receive line for a run of consecutive recessive bits. When the run is long enough, it raises the bus-active enable for the protocol engine.

A reset interrupt flag records every hardware reset and every wake from standby. The flag drives the interrupt output only while its enable bit is set, and software clears the flag by writing 1 to it. A gate output is high only in configuration mode, so that a write to the bit-timing register made outside that mode can be flagged elsewhere.

Registers: address 0 is control (bit 0 reset request, bit 1 interrupt enable). Address 1 is status (bit 0 reset status, bit 1 bus active, read-only). Address 2 is the interrupt flag (bit 0, write 1 to clear). Reads return combinationally, and unused bits read 0.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, control reads 0x01 (request 1, enable 0), rst_stat=1, rst_flag=1, bus_active=0, timing_wr_ok=1 and irq=0.
- R2: A write of 0 to control bit 0 clears rst_stat and timing_wr_ok at the clock edge that takes the write, with no write to the status register.
- R3: bus_active rises in the cycle after the strobe that carries the 11th consecutive recessive sample, and is still 0 after the 10th.
- R4: The recessive count advances only when sample_stb is high with rx_bit=1; cycles with rx_bit=1 and no strobe do not count.
- R5: A strobe with rx_bit=0 during integration resets the count, so 11 further recessive samples are needed.
- R6: A write of 1 to control bit 0 during integration or while active sets rst_stat, clears bus_active at that same edge and discards any partial count.
- R7: Writing 1 to bit 0 of address 2 clears rst_flag; writing 0 there leaves it unchanged.
- R8: A wake_pulse sets rst_flag without changing rst_stat or bus_active; a wake in the same cycle as a clear write leaves the flag set.
- R9: irq is high exactly when rst_flag=1 and control bit 1 (interrupt enable) is 1.
- R10: Status (address 1) reads rst_stat in bit 0 and bus_active in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| rx_bit | input | 1 | Receive line (1 = recessive) |
| sample_stb | input | 1 | One-cycle pulse at each bit sample point |
| wake_pulse | input | 1 | Pulse on return from standby |
| rst_stat | output | 1 | Reset-status bit (configuration mode) |
| rst_flag | output | 1 | Reset interrupt flag |
| irq | output | 1 | Interrupt request |
| bus_active | output | 1 | Protocol engine may use the bus |
| timing_wr_ok | output | 1 | High when a bit-timing write is allowed |

## Verification
The in-RTL assertions check several rules on every cycle. The status bit always mirrors the request bit. bus_active never coexists with rst_stat and rises only after a counting strobe. A dominant sample zeroes the count. The flag's set/clear priority holds, and irq follows flag and enable. Only the bench scenarios can show that exactly 11 samples are needed: the exact counts, non-strobe cycles being ignored, a partial count being discarded on re-entry, and the register read map.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [1:0] {
      MODE_CFG   = 2'd0,
      MODE_INTEG = 2'd1,
      MODE_RUN   = 2'd2
   } mode_e;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_STAT = 1;
   localparam int unsigned REG_IRQ  = 2;

   localparam int unsigned CTRL_REQ_BIT = 0;
   localparam int unsigned CTRL_IEN_BIT = 1;
endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              stat_cfg,
   input  logic              stat_run,
   input  logic              flag_in,
   output logic              req_q,
   output logic              req_nxt,
   output logic              ien_q,
   output logic              flag_clr,
   output logic [DATA_W-1:0] rdata
);
   import can_mode_pkg::*;

   logic ctrl_wr;
   logic ien_nxt;

   assign ctrl_wr  = wr && (addr == ADDR_W'(REG_CTRL));
   assign flag_clr = wr && (addr == ADDR_W'(REG_IRQ)) && wdata[0];
   assign req_nxt  = ctrl_wr ? wdata[CTRL_REQ_BIT] : req_q;
   assign ien_nxt  = ctrl_wr ? wdata[CTRL_IEN_BIT] : ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b1;
         ien_q <= 1'b0;
      end else begin
         req_q <= req_nxt;
         ien_q <= ien_nxt;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(REG_CTRL)) begin
         rdata[CTRL_REQ_BIT] = req_q;
         rdata[CTRL_IEN_BIT] = ien_q;
      end else if (addr == ADDR_W'(REG_STAT)) begin
         rdata[0] = stat_cfg;
         rdata[1] = stat_run;
      end else if (addr == ADDR_W'(REG_IRQ)) begin
         rdata[0] = flag_in;
      end
   end

   AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (req_q == $past(wdata[CTRL_REQ_BIT]))); // R2
endmodule

// File: rtl/can_integ_cnt.sv
module can_integ_cnt #(
   parameter int unsigned THRESH = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic abort,
   input  logic stb,
   input  logic rx,
   output logic done
);
   localparam int unsigned CW = $clog2(THRESH + 1);

   logic [CW-1:0] cnt;

   generate
      if (THRESH < 2) begin : g_bad_thresh
         $error("can_integ_cnt: THRESH must be at least 2");
      end
   endgenerate

   assign done = run && !abort && stb && rx && (cnt == CW'(THRESH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run || abort)   cnt <= '0;
      else if (stb) begin
         if (!rx || done)       cnt <= '0;
         else                   cnt <= cnt + CW'(1);
      end
   end

   AST_DOMINANT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (run && stb && !rx) |=> (cnt == '0)); // R5
   AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !abort && !stb) |=> $stable(cnt)); // R4
   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(THRESH)); // R3
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic req_nxt,
   input  logic done,
   output logic integ,
   output logic cfg,
   output logic run
);
   import can_mode_pkg::*;

   mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (req_nxt) mode_d = MODE_CFG;
      else begin
         unique case (mode_q)
            MODE_CFG:   mode_d = MODE_INTEG;
            MODE_INTEG: if (done) mode_d = MODE_RUN;
            MODE_RUN:   mode_d = MODE_RUN;
            default:    mode_d = MODE_CFG;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_CFG;
      else        mode_q <= mode_d;
   end

   assign cfg   = (mode_q == MODE_CFG);
   assign integ = (mode_q == MODE_INTEG);
   assign run   = (mode_q == MODE_RUN);

   AST_RUN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(done)); // R3
   AST_REQ_FORCES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      req_nxt |=> (cfg && !run)); // R6
   AST_CFG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg, integ, run})); // R6
endmodule

// File: rtl/can_reset_flag.sv
module can_reset_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wake,
   input  logic clr,
   input  logic ien,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b1;
      else if (wake)  flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
   end

   assign irq = flag && ien;

   AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> flag); // R8
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wake) |=> !flag); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ien)); // R9
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned THRESH = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              rx_bit,
   input  logic              sample_stb,
   input  logic              wake_pulse,
   output logic              rst_stat,
   output logic              rst_flag,
   output logic              irq,
   output logic              bus_active,
   output logic              timing_wr_ok
);
   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("can_mode_seq: DATA_W must be at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("can_mode_seq: ADDR_W must be at least 2");
      end
   endgenerate

   logic req_q, req_nxt, ien_q, flag_clr;
   logic integ, cfg, run, done;

   can_mode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .stat_cfg(cfg), .stat_run(run), .flag_in(rst_flag),
      .req_q(req_q), .req_nxt(req_nxt), .ien_q(ien_q), .flag_clr(flag_clr),
      .rdata(reg_rdata)
   );

   can_integ_cnt #(.THRESH(THRESH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(integ), .abort(req_nxt),
      .stb(sample_stb), .rx(rx_bit), .done(done)
   );

   can_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_nxt(req_nxt), .done(done),
      .integ(integ), .cfg(cfg), .run(run)
   );

   can_reset_flag u_flag (
      .clk(clk), .rst_n(rst_n), .wake(wake_pulse), .clr(flag_clr),
      .ien(ien_q), .flag(rst_flag), .irq(irq)
   );

   assign rst_stat     = cfg;
   assign bus_active   = run;
   assign timing_wr_ok = cfg;

   AST_HANDSHAKE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      rst_stat == req_q); // R2
   AST_NO_BUS_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_stat && bus_active)); // R6
   AST_WAKE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && !reg_wr && !sample_stb) |=> $stable(rst_stat) && $stable(bus_active)); // R8
endmodule

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
   localparam int unsigned AW = 2;
   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          rx_bit = 1'b1;
   logic          sample_stb = 1'b0;
   logic          wake_pulse = 1'b0;
   logic          rst_stat, rst_flag, irq, bus_active, timing_wr_ok;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   can_mode_seq #(.ADDR_W(AW), .DATA_W(DW), .THRESH(11)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_bit(rx_bit),
      .sample_stb(sample_stb), .wake_pulse(wake_pulse), .rst_stat(rst_stat),
      .rst_flag(rst_flag), .irq(irq), .bus_active(bus_active),
      .timing_wr_ok(timing_wr_ok)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic send(input bit v);
      @(negedge clk);
      rx_bit = v; sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0; rx_bit = 1'b1;
   endtask

   task automatic send_n(input int n, input bit v);
      for (int i = 0; i < n; i++) send(v);
   endtask

   task automatic t_reset;
      int d;
      chk("R1", "rst_stat", rst_stat, 1);
      chk("R1", "rst_flag", rst_flag, 1);
      chk("R1", "bus_active", bus_active, 0);
      chk("R1", "timing_wr_ok", timing_wr_ok, 1);
      chk("R1", "irq", irq, 0);
      rd(0, d); chk("R1", "ctrl read", d, 1);
      rd(1, d); chk("R10", "status in cfg", d, 1);
   endtask

   task automatic t_leave;
      int d;
      wr(0, 0);
      chk("R2", "rst_stat after clear", rst_stat, 0);
      chk("R2", "timing_wr_ok", timing_wr_ok, 0);
      rd(0, d); chk("R2", "ctrl read", d, 0);
      send_n(10, 1'b1);
      chk("R3", "bus_active after 10", bus_active, 0);
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R4", "bus_active after idle rx high", bus_active, 0);
      send(1'b1);
      chk("R3", "bus_active after 11", bus_active, 1);
      rd(1, d); chk("R10", "status active", d, 2);
   endtask

   task automatic t_reenter;
      wr(0, 1);
      chk("R6", "rst_stat on reentry", rst_stat, 1);
      chk("R6", "bus_active on reentry", bus_active, 0);
      wr(0, 0);
      send_n(5, 1'b1);
      wr(0, 1);
      chk("R6", "rst_stat abort integ", rst_stat, 1);
      wr(0, 0);
      send_n(10, 1'b1);
      chk("R6", "partial count discarded", bus_active, 0);
      send(1'b1);
      chk("R6", "fresh 11 enables", bus_active, 1);
   endtask

   task automatic t_dominant;
      wr(0, 1);
      wr(0, 0);
      send_n(10, 1'b1);
      send(1'b0);
      send_n(10, 1'b1);
      chk("R5", "bus_active after dominant+10", bus_active, 0);
      send(1'b1);
      chk("R5", "bus_active after dominant+11", bus_active, 1);
   endtask

   task automatic t_irq;
      chk("R9", "irq with enable 0", irq, 0);
      wr(0, 2);
      chk("R9", "irq with enable 1", irq, 1);
      chk("R9", "mode unchanged by enable", bus_active, 1);
      wr(2, 0);
      chk("R7", "write 0 keeps flag", rst_flag, 1);
      wr(2, 1);
      chk("R7", "write 1 clears flag", rst_flag, 0);
      chk("R9", "irq after clear", irq, 0);
      @(negedge clk); wake_pulse = 1'b1;
      @(negedge clk); wake_pulse = 1'b0;
      chk("R8", "wake sets flag", rst_flag, 1);
      chk("R8", "wake keeps bus_active", bus_active, 1);
      chk("R8", "wake keeps rst_stat", rst_stat, 0);
      chk("R9", "irq after wake", irq, 1);
      @(negedge clk);
      wake_pulse = 1'b1; reg_wr = 1'b1; reg_addr = AW'(2); reg_wdata = DW'(1);
      @(negedge clk);
      wake_pulse = 1'b0; reg_wr = 1'b0;
      chk("R8", "wake beats clear", rst_flag, 1);
      wr(0, 1);
      wr(2, 1);
      chk("R7", "clear in cfg", rst_flag, 0);
      @(negedge clk); wake_pulse = 1'b1;
      @(negedge clk); wake_pulse = 1'b0;
      chk("R8", "wake in cfg sets flag", rst_flag, 1);
      chk("R8", "wake keeps cfg", rst_stat, 1);
      chk("R8", "wake keeps bus off", bus_active, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_leave();
      t_reenter();
      t_dominant();
      t_irq();
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule